// File: doc/BRIEF.md
# Audio Codec Power-Management Controller

This block owns the power-enable register of an audio codec. A simple write port loads an 8-bit control word at address 0x02. Each bit of that word drives the enable of one analog sub-block: microphone preamp, ADC, DAC, common-voltage reference, headphone amplifier, speaker path, and two line-output amplifier pairs. The current word can always be read back.

The block also gates the serial ADC data stream. Whenever the ADC is switched on, that stream is held low until a warm-up interval of 4128 sample periods has passed. Sample periods are counted on a one-cycle sample-rate strobe.

The block raises a global "everything off" indication and a "clocks may stop" indication. It also keeps a sticky flag that records an attempt to run a block while the common-voltage reference is off. An active-low hardware power-down pin acts as an asynchronous reset with synchronous release. While the pin is low, every enable is forced off and the register returns to its default. In contrast, the all-zero software state keeps whatever the register holds.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After power-down release the register reads 0xEF. Bit meanings: bit7 line pair 2, bit6 line pair 1, bit5 speaker, bit4 headphone (default 0), bit3 common-voltage reference, bit2 DAC, bit1 ADC, bit0 mic. A 1 means on.
- R2: A write with `wrEn`=1 and `wrAddr`=0x02 loads `wrData`, which is visible on `rdData` after the next clock edge. Writes to any other address leave the register unchanged.
- R3: `blockEn[i]` equals register bit i while the power-down pin is high. All of `blockEn` is 0 while the pin is low, regardless of the register.
- R4: While the pin is low, the register returns to 0xEF, and the sequencing flag and the warm-up count clear.
- R5: While register bit1 (ADC) is 0, `adcDataOut` is 0.
- R6: After bit1 becomes 1, `adcReady` and `adcDataOut` stay 0 until 4128 `fsTick` pulses have been sampled with the bit at 1. After that, `adcReady` is 1 and `adcDataOut` follows `adcDataIn`.
- R7: Clearing bit1 and setting it again restarts the warm-up count from zero.
- R8: `allOff` is 1 exactly when all eight register bits are 0, and the register keeps its contents in that state.
- R9: `clkStopOk` is 1 exactly when the register is all-zero or the power-down pin holds the block in reset.
- R10: A write to 0x02 with bit3=0 and any other bit at 1 sets `seqErr`, which stays set until it is cleared.
- R11: A `statusRd` pulse clears `seqErr`. If it coincides with a write that sets the flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstPinN | input | 1 | Active-low hardware power-down, asynchronous assert |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| statusRd | input | 1 | Status read strobe, clears the sequencing flag |
| fsTick | input | 1 | One-cycle sample-rate strobe |
| adcDataIn | input | 1 | Raw serial ADC data |
| rdData | output | 8 | Current register value |
| blockEn | output | 8 | Per-block power enables |
| adcDataOut | output | 1 | Gated serial ADC data |
| adcReady | output | 1 | ADC warm-up complete and ADC enabled |
| allOff | output | 1 | Global software power-down state |
| clkStopOk | output | 1 | Audio clocks may be stopped |
| seqErr | output | 1 | Sticky sequencing-error flag |

## Verification
The hardest case to reach from the ports is an ADC warm-up that is interrupted and restarted. The restart must take effect even when the disable and enable writes are only a few cycles apart. The count must then resume from zero rather than from the partial value. The stimulus pulses `fsTick` every fourth clock and clears the ADC bit partway through a warm-up. It then re-enables the bit two cycles later and lets the full 4128-tick interval run. A behavioural model compares the exact clock in which `adcReady` rises on every cycle. A pin power-down issued in the middle of activity checks that the register default returns and the sticky flag clears.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  localparam int unsigned REG_W = 8;
  localparam logic [7:0] PWR_ADDR = 8'h02;
  localparam logic [REG_W-1:0] PWR_RESET = 8'hEF;
  localparam int unsigned ADC_BIT = 1;
  localparam int unsigned VREF_BIT = 3;

  typedef struct packed {
    logic regLoad;
    logic errSet;
    logic errClr;
    logic cntClr;
    logic cntInc;
  } pwrStrobe_t;
endpackage

// File: rtl/codec_pwr_ctl.sv
module codec_pwr_ctl
  import codec_pwr_pkg::*;
(
  input  logic             wrEn,
  input  logic [7:0]       wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic             statusRd,
  input  logic             fsTick,
  input  logic             regAdc,
  input  logic             cntDone,
  output pwrStrobe_t       strb
);
  localparam logic [REG_W-1:0] VREF_MASK = REG_W'(1) << VREF_BIT;

  logic hitReg;
  logic othersOn;

  assign hitReg   = wrEn && (wrAddr == PWR_ADDR);
  assign othersOn = |(wrData & ~VREF_MASK);

  always_comb begin
    strb.regLoad = hitReg;
    strb.errSet  = hitReg && !wrData[VREF_BIT] && othersOn;
    strb.errClr  = statusRd;
    strb.cntClr  = !regAdc;
    strb.cntInc  = regAdc && fsTick && !cntDone;
  end
endmodule

// File: rtl/codec_pwr_dp.sv
module codec_pwr_dp
  import codec_pwr_pkg::*;
#(
  parameter int unsigned WARMUP_TICKS = 4128
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwrStrobe_t       strb,
  input  logic [REG_W-1:0] wrData,
  input  logic             adcDataIn,
  output logic [REG_W-1:0] regQ,
  output logic             regAdc,
  output logic             cntDone,
  output logic             adcReady,
  output logic             adcDataOut,
  output logic [REG_W-1:0] blockEn,
  output logic             allOff,
  output logic             errQ
);
  localparam int unsigned CNT_W = $clog2(WARMUP_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WARMUP_TICKS);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             regQ <= PWR_RESET;
    else if (strb.regLoad) regQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (strb.cntClr) cntQ <= '0;
    else if (strb.cntInc) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errQ <= 1'b0;
    else if (strb.errSet) errQ <= 1'b1;
    else if (strb.errClr) errQ <= 1'b0;
  end

  assign regAdc     = regQ[ADC_BIT];
  assign cntDone    = (cntQ == CNT_END);
  assign adcReady   = regAdc & cntDone;
  assign adcDataOut = adcDataIn & adcReady;
  assign allOff     = ~|regQ;

  for (genvar g = 0; g < REG_W; g++) begin : g_en
    assign blockEn[g] = regQ[g] & rstN;
  end
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import codec_pwr_pkg::*;
#(
  parameter int unsigned WARMUP_TICKS = 4128
) (
  input  logic       clk,
  input  logic       rstPinN,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       statusRd,
  input  logic       fsTick,
  input  logic       adcDataIn,
  output logic [7:0] rdData,
  output logic [7:0] blockEn,
  output logic       adcDataOut,
  output logic       adcReady,
  output logic       allOff,
  output logic       clkStopOk,
  output logic       seqErr
);
  logic [1:0] syncQ;
  logic       rstSyncN;
  pwrStrobe_t strb;
  logic       regAdc;
  logic       cntDone;

  always_ff @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) syncQ <= '0;
    else          syncQ <= {syncQ[0], 1'b1};
  end
  assign rstSyncN = syncQ[1];

  codec_pwr_ctl u_ctl (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .statusRd (statusRd),
    .fsTick   (fsTick),
    .regAdc   (regAdc),
    .cntDone  (cntDone),
    .strb     (strb)
  );

  codec_pwr_dp #(.WARMUP_TICKS(WARMUP_TICKS)) u_dp (
    .clk        (clk),
    .rstN       (rstSyncN),
    .strb       (strb),
    .wrData     (wrData),
    .adcDataIn  (adcDataIn),
    .regQ       (rdData),
    .regAdc     (regAdc),
    .cntDone    (cntDone),
    .adcReady   (adcReady),
    .adcDataOut (adcDataOut),
    .blockEn    (blockEn),
    .allOff     (allOff),
    .errQ       (seqErr)
  );

  assign clkStopOk = allOff | ~rstSyncN;
endmodule

// File: rtl/codec_pwr_ctrl_chk.sv
module codec_pwr_ctrl_chk (
  input logic       clk,
  input logic       rstPinN,
  input logic       wrEn,
  input logic [7:0] wrAddr,
  input logic       statusRd,
  input logic       fsTick,
  input logic [7:0] rdData,
  input logic [7:0] blockEn,
  input logic       adcDataOut,
  input logic       adcReady,
  input logic       allOff,
  input logic       clkStopOk,
  input logic       seqErr
);
  p_pin_off_r3: assert property (@(posedge clk) !rstPinN |-> (blockEn == 8'h00));

  p_other_addr_r2: assert property (@(posedge clk) disable iff (!rstPinN)
    (wrEn && wrAddr != 8'h02) |=> $stable(rdData));

  p_adc_low_r5: assert property (@(posedge clk) disable iff (!rstPinN)
    !rdData[1] |-> !adcDataOut);

  p_ready_adc_r6: assert property (@(posedge clk) disable iff (!rstPinN)
    adcReady |-> rdData[1]);

  p_ready_tick_r6: assert property (@(posedge clk) disable iff (!rstPinN)
    $rose(adcReady) |-> $past(fsTick));

  p_stop_alloff_r9: assert property (@(posedge clk) disable iff (!rstPinN)
    allOff |-> clkStopOk);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstPinN)
    (seqErr && !statusRd) |=> seqErr);
endmodule

bind codec_pwr_ctrl codec_pwr_ctrl_chk u_chk (
  .clk        (clk),
  .rstPinN    (rstPinN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .statusRd   (statusRd),
  .fsTick     (fsTick),
  .rdData     (rdData),
  .blockEn    (blockEn),
  .adcDataOut (adcDataOut),
  .adcReady   (adcReady),
  .allOff     (allOff),
  .clkStopOk  (clkStopOk),
  .seqErr     (seqErr)
);

// File: tb/codec_pwr_ctrl_test.sv
`timescale 1ns/1ps
module codec_pwr_ctrl_test;
  localparam int WARM = 4128;

  logic       clk = 0;
  logic       rstPinN = 0;
  logic       wrEn = 0;
  logic [7:0] wrAddr = 0;
  logic [7:0] wrData = 0;
  logic       statusRd = 0;
  logic       fsTick = 0;
  logic       adcDataIn = 0;
  logic [7:0] rdData, blockEn;
  logic       adcDataOut, adcReady, allOff, clkStopOk, seqErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit tickEn = 1;
  int tickDiv = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int   mSync = 0;
  int   mCnt = 0;
  logic [7:0] mReg = 8'hEF;
  bit   mErr = 0;

  always #2 clk = ~clk;

  codec_pwr_ctrl uut (
    .clk(clk), .rstPinN(rstPinN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .statusRd(statusRd), .fsTick(fsTick), .adcDataIn(adcDataIn), .rdData(rdData),
    .blockEn(blockEn), .adcDataOut(adcDataOut), .adcReady(adcReady), .allOff(allOff),
    .clkStopOk(clkStopOk), .seqErr(seqErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstPinN) begin
    if (!rstPinN) begin
      mSync = 0; mReg = 8'hEF; mErr = 0; mCnt = 0;
    end else if (mSync < 2) begin
      mSync++; mReg = 8'hEF; mErr = 0; mCnt = 0;
    end else begin
      if (!mReg[1]) mCnt = 0;
      else if (fsTick && mCnt < WARM) mCnt++;
      if (wrEn && wrAddr == 8'h02 && !wrData[3] && (wrData & 8'hF7) != 0) mErr = 1;
      else if (statusRd) mErr = 0;
      if (wrEn && wrAddr == 8'h02) mReg = wrData;
    end
  end

  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 4;
    fsTick <= tickEn && (tickDiv == 0);
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    adcDataIn <= lfsr[0];
  end

  always @(negedge clk) begin
    bit act;
    bit rdy;
    #1;
    act = rstPinN && (mSync == 2);
    rdy = mReg[1] && (mCnt == WARM);
    chk("R1/R2/R4 rdData", rdData, mReg);
    chk("R3 blockEn", blockEn, act ? mReg : 8'h00);
    chk("R6 adcReady", adcReady, rdy);
    chk("R5/R6/R7 adcDataOut", adcDataOut, adcDataIn & rdy);
    chk("R8 allOff", allOff, mReg == 8'h00);
    chk("R9 clkStopOk", clkStopOk, (mReg == 8'h00) || !act);
    chk("R10/R11 seqErr", seqErr, mErr);
  end

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic probe; @(negedge clk); #2; endtask

  initial begin
    waitCyc(5); probe();
    chk("R3 pin low forces enables off", blockEn, 8'h00);
    chk("R4 default during power-down", rdData, 8'hEF);
    @(negedge clk); rstPinN = 1;
    waitCyc(5); probe();
    chk("R1 reset value", rdData, 8'hEF);
    chk("R3 enables follow register", blockEn, 8'hEF);
    waitCyc(100); probe();
    chk("R6 not ready early", adcReady, 0);
    waitCyc(WARM * 4 + 20); probe();
    chk("R6 ready after warm-up", adcReady, 1);
    wrReg(8'h02, 8'h0D); probe();
    chk("R5 adc off output low", adcDataOut, 0);
    wrReg(8'h02, 8'h0F);
    waitCyc(2000);
    wrReg(8'h02, 8'h0D);
    wrReg(8'h02, 8'h0F);
    waitCyc(WARM * 4 - 200); probe();
    chk("R7 restart not ready yet", adcReady, 0);
    waitCyc(400); probe();
    chk("R7 ready after restart", adcReady, 1);
    wrReg(8'h03, 8'h00); probe();
    chk("R2 other address ignored", rdData, 8'h0F);
    wrReg(8'h02, 8'h08); probe();
    chk("R10 vref alone no error", seqErr, 0);
    wrReg(8'h02, 8'h01); waitCyc(5); probe();
    chk("R10 sticky error", seqErr, 1);
    @(negedge clk); statusRd = 1; @(negedge clk); statusRd = 0; probe();
    chk("R11 cleared by status read", seqErr, 0);
    @(negedge clk); statusRd = 1; wrEn = 1; wrAddr = 8'h02; wrData = 8'h20;
    @(negedge clk); statusRd = 0; wrEn = 0; probe();
    chk("R11 set wins over clear", seqErr, 1);
    wrReg(8'h02, 8'h00); waitCyc(3); probe();
    chk("R8 all off", allOff, 1);
    chk("R8 contents kept", rdData, 8'h00);
    chk("R9 clocks may stop", clkStopOk, 1);
    wrReg(8'h02, 8'hFF); waitCyc(50);
    @(negedge clk); rstPinN = 0; probe();
    chk("R4 pin restores default", rdData, 8'hEF);
    chk("R4 pin clears error", seqErr, 0);
    chk("R9 clocks may stop under pin", clkStopOk, 1);
    @(negedge clk); rstPinN = 1;
    waitCyc(20);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule